// File: doc/BRIEF.md
# TDM Serial Bus to 24-Channel Slot Interface

This block sits between a 2.048 Mbit/s time-division serial bus and a 24-channel DS1 side. The bus carries frames of 32 eight-bit slots, 256 bits per 125 µs frame. A frame pulse marks where each frame begins. On the receive side the block samples the serial input on the falling edge of the bit clock and assembles each slot into a byte, MSB first. It hands a byte to the parallel side only when the slot belongs to one of the 24 DS1 channels. The other eight slots are dropped.

On the transmit side the block walks the same frame position. It names the DS1 channel whose byte is due and launches one bit of that byte on each rising edge of the bit clock. It keeps driving the line in the eight slots that carry no channel, sending all ones there. The channel-to-slot map is fixed: DS1 channel n sits in bus slot n + ⌊n/3⌋ + 1, so slots 0, 4, 8, …, 28 are the unused ones. One bit-position counter, kept on the falling edge and re-aligned by the frame pulse, sets the timing of both directions.

Top module: `tdm_bus_if`

## Requirements
- R1: While `rst_n` is low, `rx_valid` is low and `sdo` is high.
- R2: The frame pulse `fs` is sampled on the falling edge of `clk`. The bit sampled at that same edge is bit position 0 of the frame (slot 0, bit 7). Positions then advance by one per falling edge and wrap from 255 to 0 without a pulse.
- R3: Serial input is taken MSB first. After the falling edge that samples the eighth bit of a mapped slot, `rx_valid` goes high for exactly one bit period, and `rx_byte` holds the eight bits of that slot.
- R4: DS1 channel n (0..23) occupies bus slot n + ⌊n/3⌋ + 1. `rx_chan` reports n for a byte taken from that slot.
- R5: Slots whose number is a multiple of 4 (0, 4, …, 28) never raise `rx_valid`.
- R6: In a mapped slot, `sdo` carries bit 7−k of `tx_byte` during bit k of the slot (MSB first). `sdo` changes only on rising edges of `clk`.
- R7: In the unused slots (multiples of 4), `sdo` is driven high for all eight bits.
- R8: Between the falling edge that ends one bit period and the next rising edge, `tx_active` and `tx_chan` describe the slot of the bit launched at that rising edge. `tx_active` is high exactly for mapped slots, and `tx_chan` then holds the DS1 channel number. The source must hold `tx_byte` at that channel's value for the whole slot.
- R9: A frame pulse at an unexpected position, early or late, restarts the count at position 0. Receive byte boundaries follow the new pulse, and `sdo` is aligned again from the next bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus bit clock; input sampled on falling edge, output launched on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fs | input | 1 | Frame pulse, high during bit position 0 of a frame |
| sdi | input | 1 | Serial bus data in |
| sdo | output | 1 | Serial bus data out, driven in every slot |
| rx_valid | output | 1 | One-bit-period strobe for a received DS1 channel byte |
| rx_chan | output | 5 | DS1 channel number of the received byte |
| rx_byte | output | 8 | Received channel byte |
| tx_active | output | 1 | The next launched bit belongs to a mapped slot |
| tx_chan | output | 5 | DS1 channel whose byte is being transmitted |
| tx_byte | input | 8 | Byte for channel `tx_chan`, held for the slot |

## Verification
A wrong bit-position count would show on both sides within one slot. `rx_valid` would fire in a multiple-of-4 slot or carry the wrong channel number. `sdo` would send a data bit where all ones are expected, or send ones inside a mapped slot. The bench checks the receive strobe, the channel number, the byte and the serial output on every bit period. It compares them with a behavioural frame model, so a misplaced byte boundary or a lost frame re-alignment shows up no more than eight bit periods after it happens. The bench also forces early and late frame pulses, which exposes a counter that ignores re-synchronisation.

// File: rtl/tdm_bus_pkg.sv
// Shared frame geometry for the TDM bus slot interface.
// Assumes SLOT_BITS is a power of two, so a bit position splits into slot and bit fields.
package tdm_bus_pkg;
    localparam int SLOT_COUNT = 32; // slots per bus frame
    localparam int SLOT_BITS  = 8;  // bits per slot
    localparam int SLOT_GROUP = 4;  // one unused slot opens each group of this size
endpackage

// File: rtl/tdm_frame_timer.sv
// Bit-position counter for one bus frame, kept on the falling edge of the bit clock.
// The frame pulse marks the bit sampled at the same edge as position 0.
// Assumes FRAME_BITS is a power of two.
module tdm_frame_timer #(
    parameter int FRAME_BITS = 256,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs,
    output logic [POS_W-1:0] cur_pos,
    output logic [POS_W-1:0] next_pos
);
    // Position of the bit being sampled at this falling edge.
    always_comb cur_pos = fs ? '0 : next_pos;

    // Advance to the following bit position, wrapping at the end of the frame.
    always_ff @(negedge clk) begin
        if (!rst_n)
            next_pos <= '0;
        else if (cur_pos == POS_W'(FRAME_BITS - 1))
            next_pos <= '0;
        else
            next_pos <= cur_pos + 1'b1;
    end
endmodule

// File: rtl/tdm_slot_map.sv
// Fixed mapping from a bus slot to a DS1 channel: channel n sits in slot n + n/(GROUP-1) + 1.
// A slot whose number is a multiple of GROUP carries no channel.
// Assumes SLOTS is a multiple of GROUP.
module tdm_slot_map #(
    parameter int SLOTS = 32,
    parameter int GROUP = 4,
    localparam int CHANS  = SLOTS / GROUP * (GROUP - 1),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CH_W   = $clog2(CHANS)
) (
    input  logic [SLOT_W-1:0] slot,
    output logic              hit,
    output logic [CH_W-1:0]   chan
);
    logic [CHANS-1:0] match;

    // One comparator per channel against its fixed slot number.
    for (genvar n = 0; n < CHANS; n++) begin : g_chan
        localparam int SLOT_OF_N = n + n / (GROUP - 1) + 1;
        assign match[n] = (slot == SLOT_W'(SLOT_OF_N));
    end

    // Encode the single matching channel into its number.
    always_comb begin
        chan = '0;
        for (int n = 0; n < CHANS; n++)
            if (match[n]) chan = CH_W'(n);
    end

    assign hit = |match;
endmodule

// File: rtl/tdm_rx_deser.sv
// Receive deserialiser: shifts in serial data on the falling edge, MSB first.
// Emits a one-bit-period strobe with the byte and channel when a mapped slot completes.
// Assumes the caller supplies the current bit index and the slot map of the current slot.
module tdm_rx_deser #(
    parameter int BITS = 8,
    parameter int CH_W = 5,
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdi,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             slot_hit,
    input  logic [CH_W-1:0]  slot_chan,
    output logic             rx_valid,
    output logic [CH_W-1:0]  rx_chan,
    output logic [BITS-1:0]  rx_byte
);
    logic [BITS-2:0] shreg;

    // Keep the most recent bits of the slot in progress.
    always_ff @(negedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[BITS-3:0], sdi};
    end

    // Publish a completed mapped slot for one bit period.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_chan  <= '0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (bit_idx == BIT_W'(BITS - 1) && slot_hit) begin
                rx_valid <= 1'b1;
                rx_chan  <= slot_chan;
                rx_byte  <= {shreg, sdi};
            end
        end
    end
endmodule

// File: rtl/tdm_tx_ser.sv
// Transmit serialiser: launches one bit per rising edge, MSB first.
// Drives ones in slots that carry no channel.
// Assumes the byte source holds the selected channel's byte steady across the slot.
module tdm_tx_ser #(
    parameter int BITS = 8,
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             slot_hit,
    input  logic [BITS-1:0]  tx_byte,
    output logic             sdo
);
    // Select the bit for the upcoming position, or idle ones in an unused slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        sdo <= 1'b1;
        else if (slot_hit) sdo <= tx_byte[~bit_idx];
        else               sdo <= 1'b1;
    end
endmodule

// File: rtl/tdm_bus_if.sv
// TDM serial bus to 24-channel slot interface.
// Samples on the falling edge, launches on the rising edge, with both directions timed
// by one frame-pulse-aligned bit counter. Assumes SLOT_BITS and SLOT_COUNT are powers of two.
module tdm_bus_if
    import tdm_bus_pkg::*;
#(
    parameter int SLOTS = SLOT_COUNT,
    parameter int BITS  = SLOT_BITS,
    parameter int GROUP = SLOT_GROUP,
    localparam int CHANS  = SLOTS / GROUP * (GROUP - 1),
    localparam int CH_W   = $clog2(CHANS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(BITS),
    localparam int POS_W  = SLOT_W + BIT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fs,
    input  logic            sdi,
    output logic            sdo,
    output logic            rx_valid,
    output logic [CH_W-1:0] rx_chan,
    output logic [BITS-1:0] rx_byte,
    output logic            tx_active,
    output logic [CH_W-1:0] tx_chan,
    input  logic [BITS-1:0] tx_byte
);
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] next_pos;
    logic             rx_hit;
    logic [CH_W-1:0]  rx_map_chan;

    tdm_frame_timer #(.FRAME_BITS(SLOTS * BITS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fs       (fs),
        .cur_pos  (cur_pos),
        .next_pos (next_pos)
    );

    tdm_slot_map #(.SLOTS(SLOTS), .GROUP(GROUP)) u_rx_map (
        .slot (cur_pos[POS_W-1:BIT_W]),
        .hit  (rx_hit),
        .chan (rx_map_chan)
    );

    tdm_slot_map #(.SLOTS(SLOTS), .GROUP(GROUP)) u_tx_map (
        .slot (next_pos[POS_W-1:BIT_W]),
        .hit  (tx_active),
        .chan (tx_chan)
    );

    tdm_rx_deser #(.BITS(BITS), .CH_W(CH_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .bit_idx   (cur_pos[BIT_W-1:0]),
        .slot_hit  (rx_hit),
        .slot_chan (rx_map_chan),
        .rx_valid  (rx_valid),
        .rx_chan   (rx_chan),
        .rx_byte   (rx_byte)
    );

    tdm_tx_ser #(.BITS(BITS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_idx  (next_pos[BIT_W-1:0]),
        .slot_hit (tx_active),
        .tx_byte  (tx_byte),
        .sdo      (sdo)
    );
endmodule

// File: rtl/tdm_bus_chk.sv
// Property checker for the TDM bus slot interface, attached to the top by bind.
module tdm_bus_chk #(
    parameter int CHANS = 24,
    parameter int CH_W  = 5,
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fs,
    input logic             sdo,
    input logic             rx_valid,
    input logic [CH_W-1:0]  rx_chan,
    input logic             tx_active,
    input logic [CH_W-1:0]  tx_chan,
    input logic [POS_W-1:0] next_pos
);
    // R1: reset keeps the receive strobe low
    assert_reset_quiet_R1: assert property (@(negedge clk) !rst_n |=> !rx_valid);

    // R2: the pulse marks position 0, so the counter holds position 1 one edge later
    assert_pulse_aligns_R2: assert property (@(negedge clk) disable iff (!rst_n)
        fs |=> next_pos == POS_W'(1));

    // R3: the strobe lasts one bit period
    assert_strobe_single_R3: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R4: a received byte names a real channel
    assert_rx_chan_range_R4: assert property (@(negedge clk) disable iff (!rst_n)
        rx_valid |-> rx_chan < CH_W'(CHANS));

    // R7: outside mapped slots the line idles high
    assert_idle_ones_R7: assert property (@(negedge clk) disable iff (!rst_n)
        !tx_active |-> sdo);

    // R8: the transmit channel number is in range whenever a slot is active
    assert_tx_chan_range_R8: assert property (@(negedge clk) disable iff (!rst_n)
        tx_active |-> tx_chan < CH_W'(CHANS));
endmodule

bind tdm_bus_if tdm_bus_chk #(.CHANS(CHANS), .CH_W(CH_W), .POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs        (fs),
    .sdo       (sdo),
    .rx_valid  (rx_valid),
    .rx_chan   (rx_chan),
    .tx_active (tx_active),
    .tx_chan   (tx_chan),
    .next_pos  (next_pos)
);

// File: tb/tdm_bus_if_test.sv
// Bench for the TDM bus slot interface: behavioural frame model compared every bit period.
module tdm_bus_if_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fs;
    logic       sdi;
    logic       sdo;
    logic       rx_valid;
    logic [4:0] rx_chan;
    logic [7:0] rx_byte;
    logic       tx_active;
    logic [4:0] tx_chan;
    logic [7:0] tx_byte;
    logic [7:0] txmem [24];

    int checks = 0;
    int fails  = 0;
    int mpos   = -1;        // model bit position of the current period, -1 before the first pulse
    logic [7:0] acc = '0;   // model receive byte in progress
    bit   exp_known = 0;
    bit   exp_v = 0;
    int   exp_ch = 0;
    logic [7:0] exp_b = '0;
    string phase = "R2";
    bit   done = 0;

    always #4 clk = ~clk;

    assign tx_byte = txmem[tx_chan];

    tdm_bus_if uut (
        .clk(clk), .rst_n(rst_n), .fs(fs), .sdi(sdi), .sdo(sdo),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_byte(rx_byte),
        .tx_active(tx_active), .tx_chan(tx_chan), .tx_byte(tx_byte)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (%s) at pos %0d: actual %0h expected %0h", req, phase, mpos, act, exp);
        end
    endtask

    function automatic bit slot_used(input int s);
        return (s % 4) != 0;
    endfunction

    function automatic int slot_chan(input int s);
        return (s / 4) * 3 + (s % 4) - 1;
    endfunction

    task automatic fill_tx();
        for (int c = 0; c < 24; c++) txmem[c] = 8'($urandom);
    endtask

    // One bit period: drive inputs, compare outputs, advance the model.
    task automatic step(input bit fs_v, input bit sdi_v);
        int newpos, s, b;
        @(posedge clk);
        #1;
        fs  = fs_v;
        sdi = sdi_v;
        #2;
        if (exp_known) begin
            check(rx_valid == exp_v, exp_v ? "R3" : "R5", rx_valid, exp_v);
            if (exp_v && rx_valid) begin
                check(rx_chan == 5'(exp_ch), "R4", rx_chan, exp_ch);
                check(rx_byte == exp_b, "R3", rx_byte, exp_b);
            end
        end
        newpos = fs_v ? 0 : (mpos < 0 ? -1 : (mpos + 1) % 256);
        if (mpos >= 0 && newpos == (mpos + 1) % 256) begin
            s = newpos / 8;
            b = newpos % 8;
            check(tx_active == slot_used(s), "R8", tx_active, slot_used(s));
            if (slot_used(s)) begin
                check(tx_chan == 5'(slot_chan(s)), "R8", tx_chan, slot_chan(s));
                check(sdo == txmem[slot_chan(s)][7-b], "R6", sdo, txmem[slot_chan(s)][7-b]);
            end else begin
                check(sdo == 1'b1, "R7", sdo, 1);
            end
        end
        if (newpos >= 0) begin
            s = newpos / 8;
            b = newpos % 8;
            if (b == 0) acc = '0;
            acc = {acc[6:0], sdi_v};
            exp_known = 1;
            exp_v  = (b == 7) && slot_used(s);
            exp_ch = slot_chan(s);
            exp_b  = acc;
        end
        mpos = newpos;
        if (mpos == 255) fill_tx();
    endtask

    task automatic run_bits(input int n, input bit pulse_first, input int pattern);
        for (int i = 0; i < n; i++) begin
            bit d;
            case (pattern)
                0: d = 1'($urandom);
                1: d = 1'b0;
                2: d = 1'b1;
                default: d = 1'(i / 8 + i % 3);
            endcase
            step(pulse_first && i == 0, d);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        fs    = 1'b0;
        sdi   = 1'b0;
        fill_tx();
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #3;
            if (i >= 2) begin
                check(rx_valid == 1'b0, "R1", rx_valid, 0);
                check(sdo == 1'b1, "R1", sdo, 1);
            end
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        run_bits(37, 0, 0);             // free run before any pulse
        phase = "R2";
        run_bits(256, 1, 3);            // first frame, counting pattern
        run_bits(256, 1, 0);            // random data
        run_bits(256, 1, 2);            // all ones
        run_bits(256, 1, 1);            // all zeros
        run_bits(256, 0, 0);            // wrap with no pulse
        phase = "R9";
        run_bits(100, 1, 0);            // early pulse cuts this frame short
        run_bits(300, 1, 3);            // pulse is late: counter wraps on its own first
        run_bits(256, 1, 0);
        run_bits(256, 1, 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule